// File: doc/BRIEF.md
# Sequential Sign-Magnitude Integer Divider

This block divides one sign-magnitude integer by another over several clock cycles. Each operand is a sign bit and a magnitude. The magnitude arrives as a high part and a low part, 17 and 18 bits by default, which together make a 35-bit magnitude. A one-cycle start strobe captures the operands and a sign modifier. A one-cycle done pulse then presents four results: the quotient, its sign, a remainder word and a divide-exception flag. The outputs keep these values until the next operation finishes.

The block does not run a fixed number of iterations. It first shifts dividend and divisor left together until one of them has its top bit set. If the divisor becomes normalized first, the quotient is zero and the shifted dividend is returned as the remainder. Otherwise only the divisor keeps shifting until it is normalized, and the block counts those extra shifts as n. It then performs n+1 restoring shift-subtract steps. The remainder word is the true remainder scaled by the same left shift that normalized the divisor. Software that needs the plain remainder shifts it back.

Top module: `sm_divider`

## Requirements
- R1: After reset, busy, done, div_exc, quo_sign and all quotient and remainder bits are 0.
- R2: For a nonzero divisor magnitude B and dividend magnitude A, the quotient magnitude {quo_hi,quo_lo} equals floor(A/B).
- R3: For a nonzero divisor, the remainder {rem_hi,rem_lo} equals (A mod B) shifted left by the number of leading zeros of B within the magnitude width. This shift places the divisor's top bit at the magnitude MSB.
- R4: A zero divisor magnitude sets div_exc to 1 and returns a zero quotient and a zero remainder. Every other operation returns div_exc 0.
- R5: A zero dividend with a nonzero divisor finishes after one busy cycle with a zero quotient and a zero remainder.
- R6: quo_sign is the XOR of the two operand signs. The 2-bit sign modifier changes it only when the restoring loop runs, which happens when A and B are nonzero and A has no more leading zeros than B. The modifier values are: 0 keeps the sign, 1 forces 0, 2 forces 1, 3 inverts it.
- R7: busy rises in the cycle after an accepted start and stays high until the result is ready. done is a single-cycle pulse that is high exactly in the first cycle after busy falls.
- R8: With k the joint shift count and n the extra divisor shift count, the number of busy cycles is:
  - 1 for a zero operand;
  - k+2 for an early zero quotient;
  - k+3 when n is 0;
  - k+2n+4 otherwise.
  The total never exceeds 2*(magnitude width)+2.
- R9: While busy, the start strobe, the operand signs, the operand magnitudes and the sign modifier are ignored.
- R10: A start given in the same cycle as done is accepted and starts a new operation.
- R11: The result outputs and div_exc change only in the cycle where done is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, synchronized internally on release |
| start | input | 1 | Begin a division; accepted only when not busy |
| dvd_sign | input | 1 | Dividend sign |
| dvd_hi | input | HI_W | Dividend magnitude, high part |
| dvd_lo | input | LO_W | Dividend magnitude, low part |
| dvr_sign | input | 1 | Divisor sign |
| dvr_hi | input | HI_W | Divisor magnitude, high part |
| dvr_lo | input | LO_W | Divisor magnitude, low part |
| sign_mod | input | 2 | Result sign modifier |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| quo_sign | output | 1 | Quotient sign |
| quo_hi | output | HI_W | Quotient magnitude, high part |
| quo_lo | output | LO_W | Quotient magnitude, low part |
| rem_hi | output | HI_W | Scaled remainder, high part |
| rem_lo | output | LO_W | Scaled remainder, low part |
| div_exc | output | 1 | Divide exception (zero divisor) |

## Verification
The done pulse of one division and the accepted start of the next can fall in the same cycle. The sweep provokes this on purpose: every new operation is launched in the cycle where the previous one reports done. Each chained operation must then produce the right quotient, remainder, sign and exact busy length, and the bench counts how many launches met a raised done. A second overlap is also exercised. A start strobe, together with inverted operands and modifier, is driven into the first busy cycle, including the one-cycle zero-divisor case. The result must still match the captured operands.

// File: rtl/sm_div_pkg.sv
package sm_div_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_JOINT,
    ST_DVR,
    ST_LOOP
  } div_state_e;

  typedef enum logic [2:0] {
    DP_HOLD,
    DP_LOAD,
    DP_JOINT,
    DP_DVR,
    DP_STEP
  } dp_op_e;

  typedef enum logic [1:0] {
    FIN_NONE,
    FIN_ZERO,
    FIN_EARLY,
    FIN_LOOP
  } fin_e;

  function automatic logic apply_sign_mod(input logic s, input logic [1:0] m);
    case (m)
      2'd1:    return 1'b0;
      2'd2:    return 1'b1;
      2'd3:    return ~s;
      default: return s;
    endcase
  endfunction

endpackage

// File: rtl/sm_div_datapath.sv
module sm_div_datapath
  import sm_div_pkg::*;
#(
  parameter int MAG_W = 35
) (
  input  logic             clk,
  input  logic             rst_n,
  input  dp_op_e           op,
  input  logic [MAG_W-1:0] dvd_mag,
  input  logic [MAG_W-1:0] dvr_mag,
  output logic             a_top,
  output logic             b_top,
  output logic             a_zero,
  output logic             b_zero,
  output logic [MAG_W-1:0] q_next,
  output logic [MAG_W:0]   a_next
);

  // partial remainder carries one extra bit during the restoring loop
  logic [MAG_W:0]   a_q, a_d;
  logic [MAG_W-1:0] b_q, b_d;
  logic [MAG_W-1:0] q_q, q_d;
  logic [MAG_W:0]   diff;
  logic             ge;
  logic             dp_en;

  always_comb begin
    diff = a_q - {1'b0, b_q};
    ge   = (a_q >= {1'b0, b_q});
    a_d  = a_q;
    b_d  = b_q;
    q_d  = q_q;
    unique case (op)
      DP_LOAD: begin
        a_d = {1'b0, dvd_mag};
        b_d = dvr_mag;
        q_d = '0;
      end
      DP_JOINT: begin
        a_d = {a_q[MAG_W-1:0], 1'b0};
        b_d = {b_q[MAG_W-2:0], 1'b0};
      end
      DP_DVR: begin
        b_d = {b_q[MAG_W-2:0], 1'b0};
      end
      DP_STEP: begin
        q_d = {q_q[MAG_W-2:0], ge};
        a_d = ge ? {diff[MAG_W-1:0], 1'b0} : {a_q[MAG_W-1:0], 1'b0};
      end
      default: begin
      end
    endcase
  end

  assign dp_en = (op != DP_HOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= '0;
      b_q <= '0;
      q_q <= '0;
    end else if (dp_en) begin
      a_q <= a_d;
      b_q <= b_d;
      q_q <= q_d;
    end
  end

  assign a_top  = a_q[MAG_W-1];
  assign b_top  = b_q[MAG_W-1];
  assign a_zero = (a_q == '0);
  assign b_zero = (b_q == '0);
  assign q_next = q_d;
  assign a_next = a_d;

endmodule

// File: rtl/sm_div_ctrl.sv
module sm_div_ctrl
  import sm_div_pkg::*;
#(
  parameter int MAG_W = 35
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  input  logic   a_top,
  input  logic   b_top,
  input  logic   a_zero,
  input  logic   b_zero,
  output dp_op_e op,
  output fin_e   fin,
  output logic   exc_hit,
  output logic   busy
);

  localparam int CNT_W = $clog2(MAG_W + 1);

  div_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    op      = DP_HOLD;
    fin     = FIN_NONE;
    exc_hit = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          op      = DP_LOAD;
          cnt_d   = '0;
          state_d = ST_CHECK;
        end
      end
      ST_CHECK: begin
        if (b_zero) begin
          fin     = FIN_ZERO;
          exc_hit = 1'b1;
          state_d = ST_IDLE;
        end else if (a_zero) begin
          fin     = FIN_ZERO;
          state_d = ST_IDLE;
        end else begin
          state_d = ST_JOINT;
        end
      end
      ST_JOINT: begin
        if (!a_top && !b_top) begin
          op = DP_JOINT;
        end else if (!a_top) begin
          fin     = FIN_EARLY;
          state_d = ST_IDLE;
        end else if (b_top) begin
          state_d = ST_LOOP;
        end else begin
          state_d = ST_DVR;
        end
      end
      ST_DVR: begin
        if (b_top) begin
          state_d = ST_LOOP;
        end else begin
          op    = DP_DVR;
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      ST_LOOP: begin
        op = DP_STEP;
        if (cnt_q == '0) begin
          fin     = FIN_LOOP;
          state_d = ST_IDLE;
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign cnt_en = (op == DP_LOAD) || (op == DP_DVR) || (op == DP_STEP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign busy = (state_q != ST_IDLE);

endmodule

// File: rtl/sm_div_sign.sv
module sm_div_sign
  import sm_div_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic       dvd_sign,
  input  logic       dvr_sign,
  input  logic [1:0] sign_mod,
  input  fin_e       fin,
  output logic       sign_res
);

  logic       raw_q;
  logic [1:0] mod_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q <= 1'b0;
      mod_q <= 2'd0;
    end else if (load) begin
      raw_q <= dvd_sign ^ dvr_sign;
      mod_q <= sign_mod;
    end
  end

  // modifier acts only when the restoring loop produced the result
  assign sign_res = (fin == FIN_LOOP) ? apply_sign_mod(raw_q, mod_q) : raw_q;

endmodule

// File: rtl/sm_divider.sv
module sm_divider
  import sm_div_pkg::*;
#(
  parameter int HI_W = 17,
  parameter int LO_W = 18
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            dvd_sign,
  input  logic [HI_W-1:0] dvd_hi,
  input  logic [LO_W-1:0] dvd_lo,
  input  logic            dvr_sign,
  input  logic [HI_W-1:0] dvr_hi,
  input  logic [LO_W-1:0] dvr_lo,
  input  logic [1:0]      sign_mod,
  output logic            busy,
  output logic            done,
  output logic            quo_sign,
  output logic [HI_W-1:0] quo_hi,
  output logic [LO_W-1:0] quo_lo,
  output logic [HI_W-1:0] rem_hi,
  output logic [LO_W-1:0] rem_lo,
  output logic            div_exc
);

  localparam int MAG_W = HI_W + LO_W;

  logic             rst_meta_n, rst_int_n;
  dp_op_e           op;
  fin_e             fin;
  logic             exc_hit;
  logic             a_top, b_top, a_zero, b_zero;
  logic [MAG_W-1:0] q_next;
  logic [MAG_W:0]   a_next;
  logic             sign_res;
  logic             res_en;
  logic [MAG_W-1:0] quo_q, quo_d, rem_q, rem_d;
  logic             done_q, exc_q, sign_q;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_int_n  <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_int_n  <= rst_meta_n;
    end
  end

  sm_div_ctrl #(.MAG_W(MAG_W)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .start   (start),
    .a_top   (a_top),
    .b_top   (b_top),
    .a_zero  (a_zero),
    .b_zero  (b_zero),
    .op      (op),
    .fin     (fin),
    .exc_hit (exc_hit),
    .busy    (busy)
  );

  sm_div_datapath #(.MAG_W(MAG_W)) u_dp (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .op      (op),
    .dvd_mag ({dvd_hi, dvd_lo}),
    .dvr_mag ({dvr_hi, dvr_lo}),
    .a_top   (a_top),
    .b_top   (b_top),
    .a_zero  (a_zero),
    .b_zero  (b_zero),
    .q_next  (q_next),
    .a_next  (a_next)
  );

  sm_div_sign u_sign (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .load     (op == DP_LOAD),
    .dvd_sign (dvd_sign),
    .dvr_sign (dvr_sign),
    .sign_mod (sign_mod),
    .fin      (fin),
    .sign_res (sign_res)
  );

  always_comb begin
    quo_d = quo_q;
    rem_d = rem_q;
    unique case (fin)
      FIN_ZERO: begin
        quo_d = '0;
        rem_d = '0;
      end
      FIN_EARLY: begin
        quo_d = '0;
        rem_d = a_next[MAG_W-1:0];
      end
      FIN_LOOP: begin
        quo_d = q_next;
        rem_d = a_next[MAG_W:1];
      end
      default: begin
      end
    endcase
  end

  assign res_en = (fin != FIN_NONE);

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      done_q <= 1'b0;
    end else begin
      done_q <= res_en;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      quo_q  <= '0;
      rem_q  <= '0;
      exc_q  <= 1'b0;
      sign_q <= 1'b0;
    end else if (res_en) begin
      quo_q  <= quo_d;
      rem_q  <= rem_d;
      exc_q  <= exc_hit;
      sign_q <= sign_res;
    end
  end

  assign done     = done_q;
  assign div_exc  = exc_q;
  assign quo_sign = sign_q;
  assign quo_hi   = quo_q[MAG_W-1:LO_W];
  assign quo_lo   = quo_q[LO_W-1:0];
  assign rem_hi   = rem_q[MAG_W-1:LO_W];
  assign rem_lo   = rem_q[LO_W-1:0];

endmodule

// File: rtl/sm_divider_chk.sv
module sm_divider_chk #(
  parameter int HI_W = 17,
  parameter int LO_W = 18
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic            busy,
  input logic            done,
  input logic            div_exc,
  input logic            quo_sign,
  input logic [HI_W-1:0] quo_hi,
  input logic [LO_W-1:0] quo_lo,
  input logic [HI_W-1:0] rem_hi,
  input logic [LO_W-1:0] rem_lo
);

  localparam int MAG_W   = HI_W + LO_W;
  localparam int LAT_MAX = 2 * MAG_W + 2;

  int unsigned busy_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_run <= 0;
    end else begin
      busy_run <= busy ? busy_run + 1 : 0;
    end
  end

  assert_exc_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    div_exc |-> ({quo_hi, quo_lo} == '0 && {rem_hi, rem_lo} == '0));

  assert_start_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_on_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (busy_run < LAT_MAX));

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable({quo_sign, quo_hi, quo_lo, rem_hi, rem_lo, div_exc}));

endmodule

bind sm_divider sm_divider_chk #(.HI_W(HI_W), .LO_W(LO_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .busy     (busy),
  .done     (done),
  .div_exc  (div_exc),
  .quo_sign (quo_sign),
  .quo_hi   (quo_hi),
  .quo_lo   (quo_lo),
  .rem_hi   (rem_hi),
  .rem_lo   (rem_lo)
);

// File: tb/tb_sm_divider.sv
module tb_sm_divider;

  localparam int HI_W = 2;
  localparam int LO_W = 3;
  localparam int W    = HI_W + LO_W;
  localparam int MASK = (1 << W) - 1;

  logic            clk;
  logic            rst_n;
  logic            start;
  logic            dvd_sign, dvr_sign;
  logic [HI_W-1:0] dvd_hi, dvr_hi;
  logic [LO_W-1:0] dvd_lo, dvr_lo;
  logic [1:0]      sign_mod;
  logic            busy, done, quo_sign, div_exc;
  logic [HI_W-1:0] quo_hi, rem_hi;
  logic [LO_W-1:0] quo_lo, rem_lo;

  int checks;
  int errors;
  int chained;
  bit finished;

  sm_divider #(.HI_W(HI_W), .LO_W(LO_W)) dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .dvd_sign(dvd_sign), .dvd_hi(dvd_hi), .dvd_lo(dvd_lo),
    .dvr_sign(dvr_sign), .dvr_hi(dvr_hi), .dvr_lo(dvr_lo),
    .sign_mod(sign_mod), .busy(busy), .done(done), .quo_sign(quo_sign),
    .quo_hi(quo_hi), .quo_lo(quo_lo), .rem_hi(rem_hi), .rem_lo(rem_lo),
    .div_exc(div_exc)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int lzc(input int v);
    for (int i = W - 1; i >= 0; i--) begin
      if (v[i]) return W - 1 - i;
    end
    return W;
  endfunction

  function automatic logic mod_sign(input logic s, input logic [1:0] m);
    case (m)
      2'd1:    return 1'b0;
      2'd2:    return 1'b1;
      2'd3:    return ~s;
      default: return s;
    endcase
  endfunction

  // called at a negedge; returns at the negedge where done is high
  task automatic run_op(input int a, input int b, input logic sa, input logic sb,
                        input logic [1:0] m);
    int  lat, lat_e, quo_e, rem_e, k, n, la, lb;
    logic sgn_e, exc_e, loop_e;
    exc_e  = (b == 0);
    loop_e = 1'b0;
    quo_e  = 0;
    rem_e  = 0;
    lat_e  = 1;
    if (a != 0 && b != 0) begin
      la     = lzc(a);
      lb     = lzc(b);
      k      = (la < lb) ? la : lb;
      quo_e  = a / b;
      rem_e  = ((a % b) << lb) & MASK;
      loop_e = (la <= lb);
      if (!loop_e) lat_e = k + 2;
      else begin
        n     = lb - k;
        lat_e = (n == 0) ? k + 3 : k + 2 * n + 4;
      end
    end
    sgn_e = loop_e ? mod_sign(sa ^ sb, m) : (sa ^ sb);
    if (done) chained++;  // R10: launch in the done cycle
    {dvd_hi, dvd_lo} = a[W-1:0];
    {dvr_hi, dvr_lo} = b[W-1:0];
    dvd_sign = sa;
    dvr_sign = sb;
    sign_mod = m;
    start    = 1'b1;
    @(negedge clk);
    chk("R7 busy after start", busy, 1);
    // R9: disturb every input while busy
    {dvd_hi, dvd_lo} = ~a[W-1:0];
    {dvr_hi, dvr_lo} = ~b[W-1:0];
    dvd_sign = ~sa;
    dvr_sign = sa;
    sign_mod = ~m;
    lat = 0;
    do begin
      @(negedge clk);
      start = 1'b0;
      lat++;
    end while (!done && lat < 100);
    chk("R2 R9 quotient", {quo_hi, quo_lo}, quo_e);
    chk("R3 remainder", {rem_hi, rem_lo}, rem_e);
    chk("R4 exception", div_exc, exc_e);
    chk("R6 sign", quo_sign, sgn_e);
    chk("R8 latency", lat, lat_e);
    chk("R7 done with busy low", busy, 0);
    if (a == 0 && b != 0) chk("R5 zero dividend latency", lat, 1);
  endtask

  initial begin
    finished = 0;
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL R7 watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    checks = 0; errors = 0; chained = 0;
    rst_n = 1'b0; start = 1'b0;
    dvd_sign = 1'b0; dvr_sign = 1'b0; sign_mod = 2'd0;
    dvd_hi = '0; dvd_lo = '0; dvr_hi = '0; dvr_lo = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 exc", div_exc, 0);
    chk("R1 outputs", {quo_sign, quo_hi, quo_lo, rem_hi, rem_lo}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 idle after release", {busy, done}, 0);

    for (int a = 0; a <= MASK; a++) begin
      for (int b = 0; b <= MASK; b++) begin
        run_op(a, b, logic'(a[0] ^ b[1]), logic'(b[0]), 2'((a * 3 + b) % 4));
      end
    end
    chk("R10 chained launches", chained, (MASK + 1) * (MASK + 1) - 1);

    // last op was MASK/MASK: quotient 1, remainder 0
    @(negedge clk);
    chk("R7 done single pulse", done, 0);
    repeat (4) @(negedge clk);
    chk("R11 quotient held", {quo_hi, quo_lo}, 1);
    chk("R11 remainder held", {rem_hi, rem_lo}, 0);
    chk("R11 idle", busy, 0);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule